// File: doc/BRIEF.md
# UART register file with loopback

This block is the host-visible register set of a classic PC-style serial port controller, without the serialiser. A host reaches eight byte-wide registers through a 3-bit offset on a simple single-cycle bus. Received characters arrive on a byte-stream input and are held in a receive queue. Characters written by the host leave on a byte-stream output. A one-cycle interrupt pulse is raised whenever an enabled interrupt cause is added.

The block stores a 16-bit baud divisor but does no bit timing of its own. Line control bit 7 is the divisor-select bit: while it is set, offsets 0 and 1 reach the two divisor bytes. Modem control bit 4 turns on an internal loopback. While loopback is on, data writes go into the bounded receive queue instead of the output stream, and the external receive input is ignored. The interrupt identification register keeps one flag per cause and falls back to "nothing pending" after every read of it.

Bus timing: read data is combinational from the current state while `busSel` is high and `busWr` is low. Every side effect of an access takes place at the following rising clock edge. `txValid`, `txData` and `irqPulse` are registered, so they appear in the cycle after the event that causes them.

Top module: `uart_regs`

## Requirements
- R1: After reset, reads return these values: line control (offset 3) 0x03, modem control (4) 0x08, line status (5) 0x60, modem status (6) 0xB0, interrupt enable (1) 0x00, scratch (7) 0x00, interrupt identification (2) 0xC1, and data (0) 0x00. The divisor reads back as 0x000C.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. These accesses neither pop the queue, transmit, nor change interrupt enable.
- R3: A write to offset 1 with line control bit 7 clear stores only the low 4 bits of the value. Bit 0 enables the receive cause and bit 1 enables the transmit-empty cause.
- R4: Offsets 3, 4 and 7 read back the last value written. Writes to offsets 2, 5 and 6 change nothing.
- R5: With loopback off and line control bit 7 clear, a write to offset 0 makes `txValid` high for exactly one cycle in the next cycle, with `txData` equal to the written byte.
- R6: If interrupt enable bit 1 is set, the transmitting write of R5 also sets identification bit 1 (a read gives 0xC2) and pulses the interrupt.
- R7: With loopback off, a byte presented with `rxValid` enters the queue when the queue is not full. Any byte entering the queue sets line status bit 0. If interrupt enable bit 0 is set, the entry also sets identification bit 2 (a read gives 0xC4) and pulses the interrupt.
- R8: A read of offset 0 with line control bit 7 clear returns the oldest queued byte and removes it, or returns 0 when the queue is empty. It clears identification bit 2. It clears line status bit 0 when the queue held at most one byte.
- R9: A read of offset 2 returns the stored identification value ORed with 0xC0. Bit 0 of the stored value is 1 exactly when no cause is flagged, so both causes read as 0xC6. After the read, the stored value is 0x01.
- R10: While modem control bit 4 is set, a write to offset 0 goes into the receive queue and not to `txValid`. Any `rxValid` byte is discarded.
- R11: The queue holds 64 bytes. A byte offered to a full queue is dropped, with no interrupt and no change to the stored data.
- R12: A `rxValid` byte accepted in the same cycle as a data read is kept. After that cycle, line status bit 0 and identification bit 2 (when enabled) stay set.
- R13: `irqPulse` is high for one cycle after each cycle in which an enabled cause is added, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (0 when no read) |
| rxValid | input | 1 | Received byte offered this cycle |
| rxData | input | 8 | Received byte |
| txValid | output | 1 | Transmitted byte strobe |
| txData | output | 8 | Transmitted byte |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest states to reach are a completely full receive queue and a received byte that lands in the same cycle as a host pop. The first needs 64 consecutive loopback writes before any overflow behaviour can be seen. The bench enables loopback, writes 70 bytes, and then drains the queue, checking both the order of the bytes and the absence of interrupts for the dropped ones. It also drives `rxValid` during a data read with a single queued byte. A long random phase mixes loopback toggling, divisor selection and receive traffic against the behavioural model.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  // Register offsets (host-visible decode)
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_IID   = 3'd2;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_MCTL  = 3'd4;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_MSTAT = 3'd6;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  // Reset and constant values
  localparam logic [7:0]  RST_LCTL   = 8'h03;
  localparam logic [7:0]  RST_MCTL   = 8'h08;
  localparam logic [7:0]  MSTAT_VAL  = 8'hB0;
  localparam logic [15:0] RST_DIV    = 16'd12;
  localparam logic [7:0]  LSTAT_BASE = 8'h60;
  localparam logic [7:0]  IID_NONE   = 8'h01;
  localparam logic [7:0]  IID_TOP    = 8'hC0;

  localparam int LCTL_DIVSEL = 7;
  localparam int MCTL_LOOP   = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic tx;
    logic wrIen;
    logic wrLctl;
    logic wrMctl;
    logic wrScr;
    logic wrDivLo;
    logic wrDivHi;
  } strobe_t;

endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic       rxValid,
  input  logic       divSel,
  input  logic       loopOn,
  input  logic [1:0] ienCause,
  input  logic       qFull,
  output strobe_t    strb,
  output logic [7:0] iidValue,
  output logic       irqPulse
);

  logic hostWr, hostRd, dataWr, dataRd, iidRd;
  logic loopPush, extPush, pushEn, txWr;
  logic rxAdd, txAdd;
  logic rxCause, txCause;

  always_comb begin
    hostWr   = busSel & busWr;
    hostRd   = busSel & ~busWr;
    dataWr   = hostWr && (busAddr == OFS_DATA) && !divSel;
    dataRd   = hostRd && (busAddr == OFS_DATA) && !divSel;
    iidRd    = hostRd && (busAddr == OFS_IID);
    loopPush = dataWr & loopOn;
    txWr     = dataWr & ~loopOn;
    extPush  = rxValid & ~loopOn;
    pushEn   = (loopPush | extPush) & ~qFull;
    rxAdd    = pushEn & ienCause[0];
    txAdd    = txWr & ienCause[1];

    strb         = '0;
    strb.push    = pushEn;
    strb.pop     = dataRd;
    strb.tx      = txWr;
    strb.wrIen   = hostWr && (busAddr == OFS_IEN) && !divSel;
    strb.wrDivLo = hostWr && (busAddr == OFS_DATA) && divSel;
    strb.wrDivHi = hostWr && (busAddr == OFS_IEN) && divSel;
    strb.wrLctl  = hostWr && (busAddr == OFS_LCTL);
    strb.wrMctl  = hostWr && (busAddr == OFS_MCTL);
    strb.wrScr   = hostWr && (busAddr == OFS_SCR);

    iidValue = {5'b0, rxCause, txCause, ~(rxCause | txCause)};
  end

  // Cause flags: host clears first, new causes added afterwards
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCause  <= 1'b0;
      txCause  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      rxCause  <= rxAdd | (rxCause & ~iidRd & ~dataRd);
      txCause  <= txAdd | (txCause & ~iidRd);
      irqPulse <= rxAdd | txAdd;
    end
  end

  // An interrupt pulse always coincides with a flagged cause
  assert_irq_has_cause_R13: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (iidValue[2] | iidValue[1]));

  // An identification read with no new entry leaves nothing pending
  assert_iid_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (iidRd && !strb.push) |=> (iidValue == IID_NONE));

  // Loopback blocks the external input from reaching the queue
  assert_loop_blocks_rx_R10: assert property (@(posedge clk) disable iff (!rstN)
    (loopOn && rxValid && !(busSel && busWr && busAddr == OFS_DATA)) |-> !strb.push);

endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       rdEn,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  input  logic [7:0] rxData,
  input  logic [7:0] iidValue,
  output logic [7:0] busRdata,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       divSel,
  output logic       loopOn,
  output logic [1:0] ienCause,
  output logic       qFull
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [3:0]       ienReg;
  logic [7:0]       lctlReg, mctlReg, scrReg;
  logic [15:0]      divReg;
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             lsrData;
  logic             doPop, qEmpty;
  logic [7:0]       pushData, rdMux;

  always_comb begin
    qEmpty   = (count == '0);
    qFull    = (count == DEPTH_C);
    doPop    = strb.pop & ~qEmpty;
    pushData = loopOn ? busWdata : rxData;
    divSel   = lctlReg[LCTL_DIVSEL];
    loopOn   = mctlReg[MCTL_LOOP];
    ienCause = ienReg[1:0];
  end

  // Control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg  <= '0;
      lctlReg <= RST_LCTL;
      mctlReg <= RST_MCTL;
      scrReg  <= '0;
      divReg  <= RST_DIV;
    end else begin
      if (strb.wrIen)   ienReg       <= busWdata[3:0];
      if (strb.wrLctl)  lctlReg      <= busWdata;
      if (strb.wrMctl)  mctlReg      <= busWdata;
      if (strb.wrScr)   scrReg       <= busWdata;
      if (strb.wrDivLo) divReg[7:0]  <= busWdata;
      if (strb.wrDivHi) divReg[15:8] <= busWdata;
    end
  end

  // Receive queue storage
  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      count   <= '0;
      lsrData <= 1'b0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (doPop)     rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(strb.push) - CNT_W'(doPop);
      if (strb.push)
        lsrData <= 1'b1;
      else if (strb.pop && count <= CNT_W'(1))
        lsrData <= 1'b0;
    end
  end

  // Transmit stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= strb.tx;
      if (strb.tx) txData <= busWdata;
    end
  end

  // Read multiplexer
  always_comb begin
    case (busAddr)
      OFS_DATA:  rdMux = divSel ? divReg[7:0] : (qEmpty ? 8'h00 : mem[rdPtr]);
      OFS_IEN:   rdMux = divSel ? divReg[15:8] : {4'b0, ienReg};
      OFS_IID:   rdMux = iidValue | IID_TOP;
      OFS_LCTL:  rdMux = lctlReg;
      OFS_MCTL:  rdMux = mctlReg;
      OFS_LSTAT: rdMux = LSTAT_BASE | {7'b0, lsrData};
      OFS_MSTAT: rdMux = MSTAT_VAL;
      OFS_SCR:   rdMux = scrReg;
      default:   rdMux = 8'h00;
    endcase
    busRdata = rdEn ? rdMux : 8'h00;
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  assert_lsr_tracks_queue_R8: assert property (@(posedge clk) disable iff (!rstN)
    lsrData == !qEmpty);

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && qEmpty && !strb.push) |=> (count == '0));

  assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && !strb.pop) |=> qFull);

endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       irqPulse
);

  strobe_t    strb;
  logic [7:0] iidValue;
  logic       divSel, loopOn, qFull, rdEn;
  logic [1:0] ienCause;

  assign rdEn = busSel & ~busWr;

  uart_regs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .rxValid  (rxValid),
    .divSel   (divSel),
    .loopOn   (loopOn),
    .ienCause (ienCause),
    .qFull    (qFull),
    .strb     (strb),
    .iidValue (iidValue),
    .irqPulse (irqPulse)
  );

  uart_regs_dp #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdEn     (rdEn),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .rxData   (rxData),
    .iidValue (iidValue),
    .busRdata (busRdata),
    .txValid  (txValid),
    .txData   (txData),
    .divSel   (divSel),
    .loopOn   (loopOn),
    .ienCause (ienCause),
    .qFull    (qFull)
  );

endmodule

// File: tb/test_uart_regs.sv
module test_uart_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0, rxValid = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0, rxData = '0;
  logic [7:0] busRdata, txData;
  logic       txValid, irqPulse;

  uart_regs #(.DEPTH(DEPTH)) i_uart_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  logic [7:0] mq[$];
  int   mIen, mLctl, mMctl, mScr, mDiv;
  bit   mRxC, mTxC, eTx, eIrq;
  int   eTxData;
  int   total = 0, bad = 0;
  string tag = "R1";
  logic [7:0] lastRd;
  bit   finished = 0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(logic [2:0] a);
    bit dl = mLctl[7];
    int iid = (mRxC || mTxC) ? ((mRxC ? 4 : 0) | (mTxC ? 2 : 0)) : 1;
    case (a)
      3'd0: return dl ? 8'(mDiv) : (mq.size() > 0 ? mq[0] : 8'h00);
      3'd1: return dl ? 8'(mDiv >> 8) : 8'(mIen);
      3'd2: return 8'(iid | 'hC0);
      3'd3: return 8'(mLctl);
      3'd4: return 8'(mMctl);
      3'd5: return 8'(32'h60 | (mq.size() > 0 ? 1 : 0));
      3'd6: return 8'hB0;
      default: return 8'(mScr);
    endcase
  endfunction

  task automatic modelStep(bit sel, bit wr, logic [2:0] a, logic [7:0] wd, bit rv, logic [7:0] rd);
    bit dl = mLctl[7];
    bit lp = mMctl[4];
    bit full = (mq.size() >= DEPTH);
    int oldIen = mIen;
    bit push = 0, tx = 0;
    logic [7:0] pv = '0;
    eTx = 0; eIrq = 0;
    if (sel && wr) begin
      case (a)
        3'd0: if (dl) mDiv = (mDiv & 'hFF00) | int'(wd);
              else if (lp) begin if (!full) begin push = 1; pv = wd; end end
              else begin tx = 1; eTxData = int'(wd); end
        3'd1: if (dl) mDiv = (mDiv & 'hFF) | (int'(wd) << 8); else mIen = int'(wd) & 'hF;
        3'd3: mLctl = int'(wd);
        3'd4: mMctl = int'(wd);
        3'd7: mScr = int'(wd);
        default: ;
      endcase
    end
    if (sel && !wr) begin
      if (a == 3'd0 && !dl) begin
        if (mq.size() > 0) void'(mq.pop_front());
        mRxC = 0;
      end
      if (a == 3'd2) begin mRxC = 0; mTxC = 0; end
    end
    if (rv && !lp && !full) begin push = 1; pv = rd; end
    if (push) begin
      mq.push_back(pv);
      if (oldIen[0]) begin mRxC = 1; eIrq = 1; end
    end
    if (tx) begin
      eTx = 1;
      if (oldIen[1]) begin mTxC = 1; eIrq = 1; end
    end
  endtask

  // One bus cycle: drive after falling edge, compare before rising edge
  task automatic cycle(bit sel, bit wr, logic [2:0] a, logic [7:0] wd, bit rv, logic [7:0] rd);
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = a; busWdata = wd; rxValid = rv; rxData = rd;
    #(CLK_PERIOD/4);
    check("R13", {15'b0, irqPulse}, {15'b0, eIrq}, "irqPulse");
    check("R5", {15'b0, txValid}, {15'b0, eTx}, "txValid");
    if (eTx) check("R5", {8'b0, txData}, 16'(eTxData), "txData");
    lastRd = busRdata;
    if (sel && !wr) check(tag, {8'b0, busRdata}, {8'b0, modelRead(a)}, "rdata vs model");
    else check(tag, {8'b0, busRdata}, 16'h0, "rdata idle");
    modelStep(sel, wr, a, wd, rv, rd);
  endtask

  task automatic wrReg(logic [2:0] a, logic [7:0] v);
    cycle(1, 1, a, v, 0, 8'h00);
  endtask

  task automatic rdChk(logic [2:0] a, logic [7:0] exp, string req);
    tag = req;
    cycle(1, 0, a, 8'h00, 0, 8'h00);
    check(req, {8'b0, lastRd}, {8'b0, exp}, $sformatf("read offset %0d", a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 3'd0, 8'h00, 0, 8'h00);
  endtask

  task automatic rxByte(logic [7:0] b);
    cycle(0, 0, 3'd0, 8'h00, 1, b);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired R13 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    mIen = 0; mLctl = 'h03; mMctl = 'h08; mScr = 0; mDiv = 12;
    mRxC = 0; mTxC = 0; eTx = 0; eIrq = 0; eTxData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rdChk(3'd3, 8'h03, "R1"); rdChk(3'd4, 8'h08, "R1"); rdChk(3'd5, 8'h60, "R1");
    rdChk(3'd6, 8'hB0, "R1"); rdChk(3'd1, 8'h00, "R1"); rdChk(3'd7, 8'h00, "R1");
    rdChk(3'd2, 8'hC1, "R1"); rdChk(3'd0, 8'h00, "R1");
    wrReg(3'd3, 8'h83);
    rdChk(3'd0, 8'h0C, "R1"); rdChk(3'd1, 8'h00, "R1");
    wrReg(3'd3, 8'h03);

    // R3 interrupt enable masking
    wrReg(3'd1, 8'hFF); rdChk(3'd1, 8'h0F, "R3");
    wrReg(3'd1, 8'h00);

    // R4 readback and ignored writes
    wrReg(3'd7, 8'h5A); rdChk(3'd7, 8'h5A, "R4");
    wrReg(3'd3, 8'h1B); rdChk(3'd3, 8'h1B, "R4");
    wrReg(3'd4, 8'h0C); rdChk(3'd4, 8'h0C, "R4");
    wrReg(3'd5, 8'hFF); wrReg(3'd6, 8'h00); wrReg(3'd2, 8'hFF);
    rdChk(3'd5, 8'h60, "R4"); rdChk(3'd6, 8'hB0, "R4"); rdChk(3'd2, 8'hC1, "R4");
    wrReg(3'd4, 8'h08); wrReg(3'd3, 8'h03);

    // R2 divisor access
    wrReg(3'd3, 8'h80);
    wrReg(3'd0, 8'h34); wrReg(3'd1, 8'h12);
    idle(1);
    check("R2", {15'b0, txValid}, 16'h0, "no tx on divisor write");
    rdChk(3'd0, 8'h34, "R2"); rdChk(3'd1, 8'h12, "R2");
    wrReg(3'd3, 8'h03);
    rdChk(3'd1, 8'h00, "R2"); rdChk(3'd5, 8'h60, "R2");

    // R5 transmit stream
    tag = "R5";
    wrReg(3'd0, 8'h41); wrReg(3'd0, 8'h42);
    idle(1);
    check("R5", {8'b0, txData}, 16'h42, "second tx byte");
    rdChk(3'd2, 8'hC1, "R5");

    // R6 transmit-empty cause
    wrReg(3'd1, 8'h02); wrReg(3'd0, 8'h55);
    idle(1);
    check("R6", {15'b0, irqPulse}, 16'h1, "tx irq pulse");
    rdChk(3'd2, 8'hC2, "R6"); rdChk(3'd2, 8'hC1, "R9");

    // R7 / R8 receive and pop
    wrReg(3'd1, 8'h01);
    rxByte(8'hA1);
    idle(1);
    check("R7", {15'b0, irqPulse}, 16'h1, "rx irq pulse");
    rxByte(8'hA2); rxByte(8'hA3);
    rdChk(3'd5, 8'h61, "R7"); rdChk(3'd2, 8'hC4, "R7");
    rdChk(3'd0, 8'hA1, "R8"); rdChk(3'd0, 8'hA2, "R8");
    rdChk(3'd5, 8'h61, "R8");
    rdChk(3'd0, 8'hA3, "R8"); rdChk(3'd5, 8'h60, "R8"); rdChk(3'd0, 8'h00, "R8");

    // R9 both causes
    wrReg(3'd1, 8'h03);
    rxByte(8'hB7); wrReg(3'd0, 8'h66);
    rdChk(3'd2, 8'hC6, "R9"); rdChk(3'd2, 8'hC1, "R9");
    rdChk(3'd0, 8'hB7, "R8");

    // R12 receive during pop
    wrReg(3'd1, 8'h01);
    rxByte(8'h11);
    tag = "R12";
    cycle(1, 0, 3'd0, 8'h00, 1, 8'h22);
    check("R12", {8'b0, lastRd}, 16'h11, "pop with rx");
    rdChk(3'd2, 8'hC4, "R12"); rdChk(3'd5, 8'h61, "R12");
    rdChk(3'd0, 8'h22, "R12"); rdChk(3'd5, 8'h60, "R12");

    // R10 loopback
    wrReg(3'd1, 8'h00); wrReg(3'd4, 8'h18);
    tag = "R10";
    wrReg(3'd0, 8'h77);
    idle(1);
    check("R10", {15'b0, txValid}, 16'h0, "no tx in loopback");
    rxByte(8'h99);
    rdChk(3'd5, 8'h61, "R10"); rdChk(3'd0, 8'h77, "R10"); rdChk(3'd0, 8'h00, "R10");

    // R11 full queue in loopback
    wrReg(3'd1, 8'h01);
    tag = "R11";
    for (int i = 0; i < 70; i++) wrReg(3'd0, 8'(i + 1));
    idle(1);
    check("R11", {15'b0, irqPulse}, 16'h0, "no irq when full");
    rdChk(3'd2, 8'hC4, "R11");
    for (int i = 0; i < DEPTH; i++) rdChk(3'd0, 8'(i + 1), "R11");
    rdChk(3'd0, 8'h00, "R11"); rdChk(3'd5, 8'h60, "R11");
    wrReg(3'd4, 8'h08);

    // Mixed random traffic against the model
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] v = 8'($urandom_range(0, 255));
      bit rv = ($urandom_range(0, 2) == 0);
      if (a == 3'd3 && $urandom_range(0, 3) != 0) v[7] = 1'b0;
      if (a == 3'd4 && $urandom_range(0, 2) != 0) v[4] = 1'b0;
      if (op < 3) cycle(0, 0, 3'd0, 8'h00, rv, 8'($urandom_range(0, 255)));
      else if (op < 7) cycle(1, 0, a, 8'h00, rv, 8'($urandom_range(0, 255)));
      else cycle(1, 1, a, v, rv, 8'($urandom_range(0, 255)));
    end
    idle(2);

    finished = 1;
    summary();
    $finish;
  end

endmodule